// File: doc/BRIEF.md
# Debug Port Pin Handover Controller

This block arbitrates five pads that can serve either the on-chip debug port (JTAG or serial-wire) or the general-purpose I/O controller. A 3-bit configuration field, written over the register bus, picks one of four pad ownership modes. For every pad the block produces the value that the debug core sees on its input, a select telling the pad mux whether GPIO owns the pad, and the pull-up and pull-down settings in effect.

A pad leaves debug ownership in two steps. In the first cycle the core-side input of the pad is tied to a safe constant. GPIO takes over the pad controls only in the second cycle, so the debug logic never sees a glitch on its reset or clock input. To make room for this step, the configuration write that causes a release is held for one wait state through a ready signal. A pad that moves back to debug ownership needs no safe step and changes in a single cycle.

Pad index order, used by every vector port: bit 0 test-reset, bit 1 data-in, bit 2 mode-select/serial-data, bit 3 test-clock/serial-clock, bit 4 data-out.

Top module: `dbg_pin_handover`

## Requirements
- R1: After reset all five pads are debug-owned (`gpio_own_o` = 00000), `cfg_ready_o` is 1 while no write is pending, and `core_in_o` follows `pad_in_i`.
- R2: Configuration codes select the debug-owned set: 000 gives 11111, 001 gives 11110 (test-reset released), 010 gives 01100 (mode-select and clock kept), 100 gives 00000. All other codes give 00000.
- R3: In the cycle after the first clock edge of a releasing write, each released pad drives its safe level on `core_in_o` (bits 0..2 high, bit 3 low, bit 4 low) and its `gpio_own_o` bit is still 0.
- R4: After the second clock edge of a releasing write, `gpio_own_o` is 1 for exactly the pads outside the new debug-owned set.
- R5: A write that releases at least one pad sees `cfg_ready_o` low during its first cycle and high during its second. A write that releases none sees `cfg_ready_o` high at once.
- R6: A write that only adds pads to debug ownership takes effect after one clock edge, with no wait state.
- R7: A debug-owned pad has fixed pulls: pull-up on bits 0..2, pull-down on bit 3, none on bit 4.
- R8: A GPIO-owned pad passes `gpio_pu_i` and `gpio_pd_i` through to `pull_up_o` and `pull_dn_o`. A GPIO-owned pad drives its safe level on `core_in_o`.
- R9: During the safe-level cycle, pads that stay debug-owned keep forwarding `pad_in_i` to `core_in_o`.
- R10: Writing the code of the mode already in effect gives no wait state and changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe, held until ready |
| cfg_wdata_i | input | 3 | Configuration mode code |
| cfg_ready_o | output | 1 | Write completes in a cycle where this is high |
| pad_in_i | input | 5 | Pad input levels |
| gpio_pu_i | input | 5 | Pull-up request from the GPIO controller |
| gpio_pd_i | input | 5 | Pull-down request from the GPIO controller |
| core_in_o | output | 5 | Inputs as seen by the debug core |
| gpio_own_o | output | 5 | 1 where GPIO owns the pad |
| pull_up_o | output | 5 | Pull-up in effect |
| pull_dn_o | output | 5 | Pull-down in effect |

## Verification
The bench builds the block with the default 3-bit code width and five pads. At that size every start mode can be paired with every one of the eight codes. The sweep covers each release, acquire, mixed and same-mode transition, including the undefined codes. In each step the pad inputs and the GPIO pull requests change, so the safe-level cycle can be told apart from pass-through on every pad.

// File: rtl/hdov_pkg.sv
package hdov_pkg;
  localparam int unsigned NPAD  = 5;
  localparam int unsigned CFG_W = 3;

  localparam int unsigned PAD_RST = 0;
  localparam int unsigned PAD_DI  = 1;
  localparam int unsigned PAD_MS  = 2;
  localparam int unsigned PAD_CK  = 3;
  localparam int unsigned PAD_DO  = 4;

  typedef enum logic [1:0] {
    MODE_FULL    = 2'd0,
    MODE_NO_RST  = 2'd1,
    MODE_SERIAL  = 2'd2,
    MODE_OFF     = 2'd3
  } mode_e;

  typedef logic [NPAD-1:0] pad_vec_t;

  // safe core-side levels while a pad is not forwarded
  localparam pad_vec_t SAFE_LVL = pad_vec_t'((1 << PAD_RST) | (1 << PAD_DI) | (1 << PAD_MS));
  localparam pad_vec_t DBG_PU   = pad_vec_t'((1 << PAD_RST) | (1 << PAD_DI) | (1 << PAD_MS));
  localparam pad_vec_t DBG_PD   = pad_vec_t'(1 << PAD_CK);

  function automatic mode_e code_to_mode(input logic [CFG_W-1:0] code);
    mode_e m;
    case (code)
      3'b000:  m = MODE_FULL;
      3'b001:  m = MODE_NO_RST;
      3'b010:  m = MODE_SERIAL;
      default: m = MODE_OFF;
    endcase
    return m;
  endfunction

  function automatic pad_vec_t mode_to_mask(input mode_e m);
    pad_vec_t v;
    case (m)
      MODE_FULL:   v = '1;
      MODE_NO_RST: v = pad_vec_t'(~(1 << PAD_RST));
      MODE_SERIAL: v = pad_vec_t'((1 << PAD_MS) | (1 << PAD_CK));
      default:     v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/hdov_decode.sv
module hdov_decode
  import hdov_pkg::*;
#(
  parameter int unsigned CODE_W = CFG_W,
  parameter int unsigned N      = NPAD
) (
  input  logic [CODE_W-1:0] code_i,
  output mode_e             mode_o,
  output logic [N-1:0]      dbg_mask_o
);
  always_comb begin
    mode_o     = code_to_mode(code_i);
    dbg_mask_o = mode_to_mask(mode_o);
  end
endmodule

// File: rtl/hdov_seq.sv
module hdov_seq #(
  parameter int unsigned N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] next_mask_i,
  output logic [N-1:0] own_o,
  output logic [N-1:0] force_o,
  output logic         ready_o
);
  logic [N-1:0] own_q, force_q, pend_q, rel;
  logic         hold;

  assign hold    = |force_q;
  assign rel     = own_q & ~next_mask_i;
  assign ready_o = hold | ~(we_i & (|rel));
  assign own_o   = own_q;
  assign force_o = force_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_q   <= '1;
      force_q <= '0;
      pend_q  <= '1;
    end else if (hold) begin
      own_q   <= pend_q;
      force_q <= '0;
    end else if (we_i) begin
      if (|rel) begin
        force_q <= rel;
        pend_q  <= next_mask_i;
      end else begin
        own_q   <= next_mask_i;
      end
    end
  end

  a_r5_single_wait: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> ready_o);

  a_r4_release_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> ((own_q & $past(force_q)) == '0));

  a_r6_acquire_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !hold && ready_o) |=> (own_q == $past(next_mask_i)));
endmodule

// File: rtl/hdov_pad.sv
module hdov_pad #(
  parameter logic SAFE = 1'b0,
  parameter logic PU   = 1'b0,
  parameter logic PD   = 1'b0
) (
  input  logic own_i,
  input  logic force_i,
  input  logic pad_i,
  input  logic gpio_pu_i,
  input  logic gpio_pd_i,
  output logic core_o,
  output logic gpio_sel_o,
  output logic pu_o,
  output logic pd_o
);
  logic fwd;
  assign fwd        = own_i & ~force_i;
  assign core_o     = fwd ? pad_i : SAFE;
  assign gpio_sel_o = ~own_i;
  assign pu_o       = own_i ? PU : gpio_pu_i;
  assign pd_o       = own_i ? PD : gpio_pd_i;
endmodule

// File: rtl/dbg_pin_handover.sv
module dbg_pin_handover
  import hdov_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             cfg_ready_o,
  input  logic [NPAD-1:0]  pad_in_i,
  input  logic [NPAD-1:0]  gpio_pu_i,
  input  logic [NPAD-1:0]  gpio_pd_i,
  output logic [NPAD-1:0]  core_in_o,
  output logic [NPAD-1:0]  gpio_own_o,
  output logic [NPAD-1:0]  pull_up_o,
  output logic [NPAD-1:0]  pull_dn_o
);
  mode_e          mode_w;
  logic [NPAD-1:0] next_mask, own, frc;

  hdov_decode #(.CODE_W(CFG_W), .N(NPAD)) i_decode (
    .code_i    (cfg_wdata_i),
    .mode_o    (mode_w),
    .dbg_mask_o(next_mask)
  );

  hdov_seq #(.N(NPAD)) i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .next_mask_i(next_mask),
    .own_o      (own),
    .force_o    (frc),
    .ready_o    (cfg_ready_o)
  );

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    hdov_pad #(.SAFE(SAFE_LVL[p]), .PU(DBG_PU[p]), .PD(DBG_PD[p])) i_pad (
      .own_i     (own[p]),
      .force_i   (frc[p]),
      .pad_i     (pad_in_i[p]),
      .gpio_pu_i (gpio_pu_i[p]),
      .gpio_pd_i (gpio_pd_i[p]),
      .core_o    (core_in_o[p]),
      .gpio_sel_o(gpio_own_o[p]),
      .pu_o      (pull_up_o[p]),
      .pd_o      (pull_dn_o[p])
    );
  end

  a_r3_forced_safe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((frc & (core_in_o ^ SAFE_LVL)) == '0) && ((frc & gpio_own_o) == '0));

  a_r7_debug_pulls: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~gpio_own_o & ((pull_up_o ^ DBG_PU) | (pull_dn_o ^ DBG_PD))) == '0));

  a_r2_mode_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_w == MODE_OFF) |-> (next_mask == '0));
endmodule

// File: tb/test_dbg_pin_handover.sv
module test_dbg_pin_handover;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [2:0] cfg_wdata_i = '0;
  logic       cfg_ready_o;
  logic [4:0] pad_in_i = '0, gpio_pu_i = '0, gpio_pd_i = '0;
  logic [4:0] core_in_o, gpio_own_o, pull_up_o, pull_dn_o;

  int total = 0, bad = 0;
  logic done = 1'b0;
  logic [4:0] cur;

  localparam logic [4:0] SAFE = 5'b00111;
  localparam logic [4:0] PU   = 5'b00111;
  localparam logic [4:0] PD   = 5'b01000;

  always #4 clk_i = ~clk_i;

  dbg_pin_handover i_dbg_pin_handover (.*);

  function automatic logic [4:0] exp_mask(input logic [2:0] c);
    case (c)
      3'd0: return 5'b11111;
      3'd1: return 5'b11110;
      3'd2: return 5'b01100;
      default: return 5'b00000;
    endcase
  endfunction

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic check_static(input logic [4:0] own, input string req);
    chk(req, gpio_own_o, ~own);
    chk(req, core_in_o, (own & pad_in_i) | (~own & SAFE));
    chk("R7", pull_up_o & own, PU & own);
    chk("R7", pull_dn_o & own, PD & own);
    chk("R8", pull_up_o & ~own, gpio_pu_i & ~own);
    chk("R8", pull_dn_o & ~own, gpio_pd_i & ~own);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0; cfg_we_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pad_in_i = 5'b10110; gpio_pu_i = 5'b10101; gpio_pd_i = 5'b01010;
    #1;
    cur = 5'b11111;
    chk("R1", {4'b0, cfg_ready_o}, 5'd1);
    check_static(cur, "R1");
  endtask

  task automatic do_write(input logic [2:0] code, input logic [4:0] pat);
    logic [4:0] nw, rel;
    nw  = exp_mask(code);
    rel = cur & ~nw;
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_wdata_i = code; pad_in_i = pat;
    gpio_pu_i = ~pat; gpio_pd_i = {pat[0], pat[4:1]};
    #1;
    chk("R5", {4'b0, cfg_ready_o}, (rel != 0) ? 5'd0 : 5'd1);
    @(negedge clk_i); #1;
    if (rel != 0) begin
      chk("R3", core_in_o & rel, SAFE & rel);
      chk("R3", gpio_own_o, ~cur);
      chk("R5", {4'b0, cfg_ready_o}, 5'd1);
      chk("R9", core_in_o, (cur & ~rel & pad_in_i) | ((~cur | rel) & SAFE));
      pad_in_i = ~pad_in_i; #1;
      chk("R9", core_in_o, (cur & ~rel & pad_in_i) | ((~cur | rel) & SAFE));
      @(negedge clk_i); #1;
      cfg_we_i = 1'b0;
      check_static(nw, "R4");
    end else begin
      cfg_we_i = 1'b0;
      check_static(nw, (nw == cur) ? "R10" : "R6");
    end
    chk("R2", ~gpio_own_o, nw);
    cur = nw;
  endtask

  initial begin
    do_reset();
    for (int f = 0; f < 8; f++) begin
      for (int t = 0; t < 8; t++) begin
        do_reset();
        do_write(3'(f), 5'(f * 7 + t * 3 + 1));
        do_write(3'(t), 5'(t * 11 + f * 5 + 2));
      end
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule